// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one channel of a DMA engine that follows a chain of descriptors kept in memory. Each descriptor is four little-endian 32-bit words: a link word, a source address, a destination address and a command word. When software sets the run bit, the channel reads the descriptor at the programmed address. It then copies the byte count, one unit at a time. A unit is 1, 2 or 4 bytes: the channel reads it from the source and writes it to the destination. At the end of a descriptor it either follows the link or stops.

Software uses two registers, selected by `reg_sel`: a control/status word (select 0) and a descriptor pointer (select 1). Memory traffic goes through one request/grant port, with right-aligned data and a size code. A peripheral request input paces the transfer in bursts when the descriptor asks for flow control.

Top module: `chain_dma_chan`

## Requirements
- R1: A descriptor fetch issues four 4-byte reads (size code 2) at pointer, pointer+4, pointer+8 and pointer+12, in that order. They load the link, source, destination and command words. Each request holds its address until `mem_gnt`.
- R2: Command bits 15:14 choose the unit width: 3 means 4 bytes, 2 means 2 bytes, and 0 or 1 mean 1 byte. The size code is log2 of the width. Bits 12:0 hold the byte length, and the channel moves ceil(length/width) units. A length of 0 moves no data.
- R3: Command bit 31 advances the source address by the width after every unit, and bit 30 does the same for the destination. A clear bit keeps that address fixed.
- R4: Command bits 17:16 set the burst bytes: 3 means 32, 2 means 16, and 0 or 1 mean 8. A burst is burst bytes divided by width, in units. When command bit 29 or bit 28 is set, each burst starts only after `periph_req` is sampled high. Otherwise bursts run back to back.
- R5: The next descriptor address is link bits 31:4 with the low four bits zero. Link bit 0 set ends the chain after the current descriptor. At the end of the chain, control bit 31 (run) clears and control bit 3 (stopped) reads 1.
- R6: Status bit 1 sets when a descriptor with command bit 22 is loaded. Status bit 2 sets when a descriptor with command bit 21 completes.
- R7: A grant with `mem_err` high sets status bit 0 and clears run. No request follows in the next cycle.
- R8: A control write clears each of status bits 2:0 where the written value has a 1. Writing back the read value clears exactly the flags that were set.
- R9: Writing run as 0 stops the channel after the memory access in progress completes, and stopped then reads 1.
- R10: Control bit 30 (no further fetch) makes the channel stop after the current descriptor even when the link has no stop flag.
- R11: `irq` is high while any of status bits 2:0 is set, or while control bit 29 is set and the channel is stopped.
- R12: Control bit 8 mirrors `periph_req`. After reset the control word reads 0x00000008 with `periph_req` low, and `mem_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control/status, 1 selects descriptor pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | log2 of access bytes |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, valid with grant |
| mem_rdata | input | 32 | Right-aligned read data, valid with grant |
| periph_req | input | 1 | Peripheral flow-control request |
| irq | output | 1 | Interrupt |

## Verification
A wrong sequencer state shows at the memory port within one grant: an extra or missing read, or a wrong address or size. It also shows as destination bytes that differ from the bench's arithmetic copy model once the chain stops. Counter faults in the length or burst logic change the number of source reads. The bench counts those reads at the pause points of a flow-controlled transfer. Flag and run-bit faults appear on the control word and on `irq` in the cycle after the event.

// File: rtl/chain_dma_pkg.sv
// Shared types and helpers for the linked-list DMA channel.
// Assumes 32-bit descriptor words and a 13-bit byte length field.
package chain_dma_pkg;

    localparam int unsigned LEN_W   = 13;
    localparam int unsigned BCNT_W  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_DONE
    } eng_state_t;

    typedef struct packed {
        logic             src_inc;
        logic             dst_inc;
        logic             pace_src;
        logic             pace_dst;
        logic             start_ie;
        logic             end_ie;
        logic [1:0]       burst;
        logic [1:0]       width;
        logic [LEN_W-1:0] len;
    } cmd_t;

    // Pull the command fields out of a raw command word.
    function automatic cmd_t unpack_cmd(input logic [31:0] w);
        cmd_t c;
        c.src_inc  = w[31];
        c.dst_inc  = w[30];
        c.pace_src = w[29];
        c.pace_dst = w[28];
        c.start_ie = w[22];
        c.end_ie   = w[21];
        c.burst    = w[17:16];
        c.width    = w[15:14];
        c.len      = w[LEN_W-1:0];
        return c;
    endfunction

    // log2 of the unit width in bytes.
    function automatic logic [1:0] unit_log2(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : (code == 2'd2) ? 2'd1 : 2'd0;
    endfunction

    // Units per burst: burst bytes divided by unit bytes.
    function automatic logic [BCNT_W-1:0] burst_units(input cmd_t c);
        logic [2:0] blog;
        blog = (c.burst == 2'd3) ? 3'd5 : (c.burst == 2'd2) ? 3'd4 : 3'd3;
        return BCNT_W'(1) << (blog - {1'b0, unit_log2(c.width)});
    endfunction

endpackage

// File: rtl/chain_dma_csr.sv
// Control/status and descriptor pointer registers of the channel.
// Holds run, no-further-fetch, stop-interrupt enable and the three
// sticky flags; derives the interrupt. Event inputs are one-cycle pulses.
module chain_dma_csr
    import chain_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              periph_req,
    input  logic              eng_idle,
    input  logic              start_evt,
    input  logic              end_evt,
    input  logic              err_evt,
    input  logic              chain_done,
    output logic [31:0]       reg_rdata,
    output logic              run,
    output logic              nofetch,
    output logic [ADDR_W-1:0] desc_base,
    output logic [2:0]        flags,
    output logic              irq
);

    logic       stop_ie;
    logic       ctl_wr;
    logic [2:0] clr_mask;

    // Decode a write to the control word.
    always_comb begin
        ctl_wr   = reg_we && !reg_sel;
        clr_mask = ctl_wr ? reg_wdata[2:0] : 3'b000;
    end

    // Register update: events win over software clears and run writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            nofetch   <= 1'b0;
            stop_ie   <= 1'b0;
            flags     <= 3'b000;
            desc_base <= '0;
        end else begin
            if (ctl_wr) begin
                nofetch <= reg_wdata[30];
                stop_ie <= reg_wdata[29];
            end
            if (chain_done || err_evt)
                run <= 1'b0;
            else if (ctl_wr)
                run <= reg_wdata[31];
            flags <= (flags & ~clr_mask) | {end_evt, start_evt, err_evt};
            if (reg_we && reg_sel)
                desc_base <= {reg_wdata[ADDR_W-1:4], 4'b0000};
        end
    end

    // Read mux and interrupt output.
    always_comb begin
        if (reg_sel)
            reg_rdata = 32'(desc_base);
        else
            reg_rdata = {run, nofetch, stop_ie, 20'b0, periph_req, 4'b0,
                         eng_idle, flags};
        irq = (|flags) || (stop_ie && eng_idle);
    end

endmodule

// File: rtl/chain_dma_engine.sv
// Descriptor walker and copy sequencer for one channel.
// Assumes the memory port completes an access in the cycle mem_gnt is
// high, with mem_rdata/mem_err valid in that cycle; data is right-aligned.
module chain_dma_engine
    import chain_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              nofetch,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic              periph_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              eng_idle,
    output logic              start_evt,
    output logic              end_evt,
    output logic              err_evt,
    output logic              chain_done
);

    eng_state_t        state;
    logic [ADDR_W-1:0] ptr, src, dst;
    logic [1:0]        widx;
    logic [31:0]       link_w, data_q;
    cmd_t              cmd;
    logic [LEN_W-1:0]  remain;
    logic [BCNT_W-1:0] bcnt;

    cmd_t              fetched;
    logic [1:0]        ulog;
    logic [2:0]        ubytes;
    logic              paced, ok, bad, last_unit;

    // Per-cycle decode of the active command and the grant outcome.
    always_comb begin
        fetched   = unpack_cmd(mem_rdata);
        ulog      = unit_log2(cmd.width);
        ubytes    = 3'd1 << ulog;
        paced     = cmd.pace_src || cmd.pace_dst;
        ok        = mem_req && mem_gnt && !mem_err;
        bad       = mem_req && mem_gnt && mem_err;
        last_unit = remain <= LEN_W'(ubytes);
    end

    // Memory port drive from the current state.
    always_comb begin
        mem_req   = (state == ST_FETCH) || (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_size  = (state == ST_FETCH) ? 2'd2 : ulog;
        mem_wdata = data_q;
        case (state)
            ST_FETCH: mem_addr = ptr + ADDR_W'({widx, 2'b00});
            ST_WR:    mem_addr = dst;
            default:  mem_addr = src;
        endcase
    end

    // Event pulses towards the register block.
    always_comb begin
        eng_idle   = (state == ST_IDLE);
        start_evt  = ok && (state == ST_FETCH) && (widx == 2'd3) && fetched.start_ie;
        end_evt    = (state == ST_DONE) && cmd.end_ie;
        err_evt    = bad;
        chain_done = (state == ST_DONE) && (link_w[0] || nofetch);
    end

    // Sequencer: fetch, optional pacing wait, read/write units, chain step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            src    <= '0;
            dst    <= '0;
            widx   <= 2'd0;
            link_w <= '0;
            data_q <= '0;
            cmd    <= '0;
            remain <= '0;
            bcnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (run) begin
                        ptr   <= desc_base;
                        widx  <= 2'd0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (bad) begin
                        state <= ST_IDLE;
                    end else if (ok) begin
                        widx <= widx + 2'd1;
                        case (widx)
                            2'd0: link_w <= mem_rdata;
                            2'd1: src    <= ADDR_W'(mem_rdata);
                            2'd2: dst    <= ADDR_W'(mem_rdata);
                            default: begin
                                cmd    <= fetched;
                                remain <= fetched.len;
                                bcnt   <= burst_units(fetched);
                            end
                        endcase
                        if (!run)
                            state <= ST_IDLE;
                        else if (widx == 2'd3) begin
                            if (fetched.len == '0)
                                state <= ST_DONE;
                            else if (fetched.pace_src || fetched.pace_dst)
                                state <= ST_WAIT;
                            else
                                state <= ST_RD;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!run)
                        state <= ST_IDLE;
                    else if (periph_req)
                        state <= ST_RD;
                end
                ST_RD: begin
                    if (bad) begin
                        state <= ST_IDLE;
                    end else if (ok) begin
                        data_q <= mem_rdata;
                        state  <= run ? ST_WR : ST_IDLE;
                    end
                end
                ST_WR: begin
                    if (bad) begin
                        state <= ST_IDLE;
                    end else if (ok) begin
                        if (cmd.src_inc) src <= src + ADDR_W'(ubytes);
                        if (cmd.dst_inc) dst <= dst + ADDR_W'(ubytes);
                        remain <= last_unit ? '0 : remain - LEN_W'(ubytes);
                        if (last_unit)
                            state <= ST_DONE;
                        else if (!run)
                            state <= ST_IDLE;
                        else if (bcnt == BCNT_W'(1)) begin
                            bcnt  <= burst_units(cmd);
                            state <= paced ? ST_WAIT : ST_RD;
                        end else begin
                            bcnt  <= bcnt - BCNT_W'(1);
                            state <= ST_RD;
                        end
                    end
                end
                ST_DONE: begin
                    if (!run || link_w[0] || nofetch) begin
                        state <= ST_IDLE;
                    end else begin
                        ptr   <= {link_w[ADDR_W-1:4], 4'b0000};
                        widx  <= 2'd0;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/chain_dma_chan.sv
// Top of one linked-list DMA channel: register block plus sequencer.
// Assumes a single-cycle completing request/grant memory port.
module chain_dma_chan
    import chain_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    input  logic              periph_req,
    output logic              irq
);

    logic              run, nofetch, eng_idle;
    logic              start_evt, end_evt, err_evt, chain_done;
    logic [ADDR_W-1:0] desc_base;
    logic [2:0]        flag_q;

    chain_dma_csr #(.ADDR_W(ADDR_W)) csr_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .periph_req(periph_req), .eng_idle(eng_idle),
        .start_evt(start_evt), .end_evt(end_evt), .err_evt(err_evt),
        .chain_done(chain_done),
        .reg_rdata(reg_rdata), .run(run), .nofetch(nofetch),
        .desc_base(desc_base), .flags(flag_q), .irq(irq)
    );

    chain_dma_engine #(.ADDR_W(ADDR_W)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .run(run), .nofetch(nofetch), .desc_base(desc_base),
        .periph_req(periph_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .eng_idle(eng_idle), .start_evt(start_evt), .end_evt(end_evt),
        .err_evt(err_evt), .chain_done(chain_done)
    );

endmodule

// File: rtl/chain_dma_chan_chk.sv
// Protocol and control checks for chain_dma_chan, attached by bind.
module chain_dma_chan_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_size,
    input logic              mem_gnt,
    input logic              mem_err,
    input logic              run,
    input logic              eng_idle,
    input logic [2:0]        flag_q
);

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

    // R2
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size != 2'd3);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && mem_err |=> !mem_req);

    // R7
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && mem_err |=> flag_q[0] && !run);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_idle && !run && !reg_we |=> !mem_req);

endmodule

bind chain_dma_chan chain_dma_chan_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_gnt(mem_gnt), .mem_err(mem_err),
    .run(run), .eng_idle(eng_idle), .flag_q(flag_q)
);

// File: tb/chain_dma_chan_tb_top.sv
// Self-checking bench: byte memory model with grant delay and error
// injection, sweeps over width, increment and length, plus chain tests.
module chain_dma_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_gnt = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        periph_req = 1'b0;
    logic        irq;

    int unsigned vectors = 0;
    int unsigned errors  = 0;
    int unsigned rd_cnt  = 0;
    int unsigned gnt_delay = 0;
    int unsigned wait_cnt = 0;
    logic        err_en = 1'b0;
    logic [9:0]  err_addr = '0;
    logic [7:0]  mem [0:1023];
    logic [7:0]  exp_b [0:63];

    always #2.5 clk = ~clk;

    chain_dma_chan dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .periph_req(periph_req), .irq(irq)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // Memory responder, acting between clock edges.
    always @(negedge clk) begin
        mem_gnt = 1'b0;
        mem_err = 1'b0;
        if (rst_n && mem_req) begin
            if (wait_cnt >= gnt_delay) begin
                wait_cnt = 0;
                mem_gnt  = 1'b1;
                mem_err  = err_en && (mem_addr[9:0] == err_addr);
                mem_rdata = '0;
                for (int b = 0; b < (1 << mem_size); b++) begin
                    if (mem_we && !mem_err)
                        mem[(mem_addr[9:0] + b) & 1023] = mem_wdata[8*b +: 8];
                    mem_rdata[8*b +: 8] = mem[(mem_addr[9:0] + b) & 1023];
                end
                if (!mem_we) rd_cnt++;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic mem_init();
        for (int a = 0; a < 1024; a++) mem[a] = (a >= 'h200 && a < 'h300) ? 8'hEE : pat(a);
        rd_cnt = 0;
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) mem[a + b] = v[8*b +: 8];
    endtask

    task automatic put_desc(input int a, input logic [31:0] link, input logic [31:0] s,
                            input logic [31:0] t, input logic [31:0] c);
        put32(a, link); put32(a + 4, s); put32(a + 8, t); put32(a + 12, c);
    endtask

    task automatic wait_stop(input string req);
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (!reg_rdata[31] && reg_rdata[3]) return;
        end
        check(req, 32'hDEAD, 32'h0);
    endtask

    task automatic go(input int d, input logic [31:0] extra, input string req);
        reg_write(1'b1, 32'(d));
        reg_write(1'b0, 32'h8000_0000 | extra);
        wait_stop(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected stop");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset csr", reg_rdata, 32'h0000_0008);
        check("R12 reset req/irq", {30'b0, mem_req, irq}, 32'h0);
        periph_req = 1'b1;
        @(negedge clk);
        check("R12 req mirror", reg_rdata & 32'h100, 32'h100);

        // R2/R3 sweep over width, increments and lengths
        for (int wc = 1; wc <= 3; wc++) begin
            for (int inc = 0; inc < 4; inc++) begin
                for (int li = 0; li < 5; li++) begin
                    int len, w, units, si, ti, mism;
                    logic [31:0] cmd;
                    len = (li == 0) ? 1 : (li == 1) ? 2 : (li == 2) ? 5 : (li == 3) ? 8 : 13;
                    w = 1 << (wc - 1);
                    si = inc & 1; ti = inc >> 1;
                    units = (len + w - 1) / w;
                    gnt_delay = (wc + li) % 3;
                    mem_init();
                    cmd = (32'(si) << 31) | (32'(ti) << 30) | (32'(len & 1) << 29)
                        | (32'(wc) << 14) | 32'(len);
                    put_desc('h40, 32'h1, 32'h100, 32'h200, cmd);
                    for (int i = 0; i < 64; i++) exp_b[i] = 8'hEE;
                    for (int k = 0; k < units; k++)
                        for (int j = 0; j < w; j++)
                            exp_b[(ti ? k * w : 0) + j] = pat('h100 + (si ? k * w : 0) + j);
                    go('h40, 32'h0, "R2 sweep timeout");
                    mism = 0;
                    for (int i = 0; i < 64; i++) if (mem['h200 + i] !== exp_b[i]) mism++;
                    check($sformatf("R2/R3 copy w%0d si%0d ti%0d len%0d", w, si, ti, len),
                          32'(mism), 32'h0);
                    check("R2 source reads", rd_cnt, 32'(4 + units));
                end
            end
        end
        gnt_delay = 1;

        // R5/R6 two-descriptor chain with start on first, end on second
        mem_init();
        put_desc('h40, 32'h80, 32'h100, 32'h200, (32'h1 << 22) | (32'h3 << 30) | (32'h1 << 14) | 32'd4);
        put_desc('h80, 32'h1, 32'h140, 32'h240, (32'h1 << 21) | (32'h3 << 30) | (32'h1 << 14) | 32'd3);
        go('h40, 32'h0, "R5 chain timeout");
        check("R5 chain first", {mem['h203], mem['h200]}, {pat('h103), pat('h100)});
        check("R5 chain second", {mem['h242], mem['h243]}, {pat('h142), 8'hEE});
        check("R1 fetch count", rd_cnt, 32'd15);
        check("R6 flags", reg_rdata & 32'h8000_000F, 32'h0000_000E);
        check("R11 irq flags", 32'(irq), 32'h1);
        reg_write(1'b0, reg_rdata);
        @(negedge clk);
        check("R8 w1c", reg_rdata & 32'h7, 32'h0);
        check("R11 irq clear", 32'(irq), 32'h0);

        // R11 stop-interrupt enable while stopped
        reg_write(1'b0, 32'h2000_0000);
        @(negedge clk);
        check("R11 stop irq", 32'(irq), 32'h1);
        reg_write(1'b0, 32'h0);
        @(negedge clk);
        check("R11 stop irq off", 32'(irq), 32'h0);

        // R10 no further fetch
        mem_init();
        put_desc('h40, 32'h80, 32'h100, 32'h200, (32'h3 << 30) | (32'h1 << 14) | 32'd2);
        put_desc('h80, 32'h1, 32'h140, 32'h240, (32'h3 << 30) | (32'h1 << 14) | 32'd2);
        go('h40, 32'h4000_0000, "R10 timeout");
        check("R10 first done", 32'(mem['h201]), 32'(pat('h101)));
        check("R10 second skipped", 32'(mem['h240]), 32'hEE);
        reg_write(1'b0, 32'h0);

        // R4 paced bursts: 8-byte bursts of 1-byte units, length 20
        mem_init();
        periph_req = 1'b0;
        put_desc('h40, 32'h1, 32'h100, 32'h200, (32'h3 << 30) | (32'h1 << 29) | (32'h1 << 16) | (32'h1 << 14) | 32'd20);
        reg_write(1'b1, 32'h40);
        reg_write(1'b0, 32'h8000_0000);
        repeat (40) @(negedge clk);
        check("R4 wait before burst", rd_cnt, 32'd4);
        check("R12 req low", reg_rdata & 32'h108, 32'h0);
        periph_req = 1'b1;
        @(negedge clk);
        periph_req = 1'b0;
        repeat (60) @(negedge clk);
        check("R4 one burst", rd_cnt, 32'd12);
        periph_req = 1'b1;
        wait_stop("R4 timeout");
        check("R4 all units", rd_cnt, 32'd24);
        check("R4 last byte", 32'(mem['h213]), 32'(pat('h113)));

        // R9 run cleared while waiting for pacing
        mem_init();
        periph_req = 1'b0;
        reg_write(1'b1, 32'h40);
        reg_write(1'b0, 32'h8000_0000);
        repeat (20) @(negedge clk);
        reg_write(1'b0, 32'h0);
        repeat (2) @(negedge clk);
        check("R9 stopped", reg_rdata & 32'h8000_0008, 32'h0000_0008);
        repeat (20) @(negedge clk);
        check("R9 no reads", rd_cnt, 32'd4);
        periph_req = 1'b1;

        // R7 bus error on third source read
        mem_init();
        err_en = 1'b1; err_addr = 10'h102;
        put_desc('h40, 32'h1, 32'h100, 32'h200, (32'h3 << 30) | (32'h1 << 14) | 32'd8);
        go('h40, 32'h0, "R7 timeout");
        err_en = 1'b0;
        check("R7 status", reg_rdata & 32'h8000_000F, 32'h0000_0009);
        check("R7 partial copy", {mem['h201], mem['h202]}, {pat('h101), 8'hEE});
        reg_write(1'b0, reg_rdata);
        @(negedge clk);
        check("R8 clear buserr", reg_rdata & 32'h7, 32'h0);

        // R2 zero length moves nothing
        mem_init();
        put_desc('h40, 32'h1, 32'h100, 32'h200, (32'h3 << 30) | (32'h3 << 14));
        go('h40, 32'h0, "R2 zero timeout");
        check("R2 zero reads", rd_cnt, 32'd4);
        check("R2 zero data", 32'(mem['h200]), 32'hEE);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule